// File: doc/BRIEF.md
# Byte ALU and Instruction Decoder

This block is the combinational decode and execute stage of a small 8-bit controller core. It takes a 14-bit instruction word, the working register W, the byte read from the addressed file register, and the current carry flag. In the same cycle it produces the result byte, a write enable for W or for the file register, the 7-bit register address, new carry, half-carry and zero flags each with its own update enable, and a request to skip the next instruction. Instructions that reach other parts of the core (watchdog clear, sleep, timer-mode load, return) show up only as one-cycle strobes.

The enclosing core supplies the register file read data from `addr_o`, commits `result_o` to W or to the file register when the matching enable is high, and merges the flag outputs into its status register under their enables. Program counter, stack, register file and timers are outside this block.

Top module: `byte_alu_exec`

## Requirements
- R1: `addr_o` always equals instr[6:0]. For byte-register operations, instr[7]=0 writes the result to W (`w_we_o`=1) and instr[7]=1 writes it to the file register (`reg_we_o`=1). The two enables are never high together.
- R2: Opcode instr[13:8]=011011 gives result=(W+R) mod 256, C=carry out of bit 7, HC=carry out of the low nibble sum, Z=(result==0). All three flag enables are high.
- R3: Opcode 011100 gives result=(R−W) mod 256, formed as R plus inverted W plus one. C=1 when R≥W (no borrow), HC=1 when R[3:0]≥W[3:0], Z=(result==0). All three flag enables are high.
- R4: Opcodes 010010, 010011, 010100 give AND, OR, XOR of W with R to the selected destination. Opcodes 110100, 110101, 110110 give the same operations with the immediate instr[7:0] and always write W. All six update only Z.
- R5: Opcode 010110 gives result={C,R[7:1]} with new C=R[0]. Opcode 010101 gives result={R[6:0],C} with new C=R[7]. Only C is updated.
- R6: Opcode 010111 gives result={R[3:0],R[7:4]} with no flag update. Opcode 011111 gives result=~R and updates Z.
- R7: Opcodes 011001 and 011101 give R+1 and R−1 (mod 256) and update Z. Opcodes 011010 and 011110 give the same results with no flag update, and raise `skip_o` when the result is zero.
- R8: When instr[13:12]=00 and instr[10]=0, the file register is written with R. Bit instr[9:7] is cleared if instr[11]=0 and set if instr[11]=1. No flag is updated.
- R9: When instr[13:12]=00 and instr[10]=1, nothing is written. `skip_o` is 1 when bit instr[9:7] of R is 0 (instr[11]=0) or is 1 (instr[11]=1).
- R10: 111010 loads W with instr[7:0], no flags. 010000 with instr[7]=1 clears W with Z=1. 010001 with instr[7]=0 clears the file register with Z=1. 010001 with instr[7]=1 writes W to the file register with no flags. 011000 moves R to the selected destination and updates Z.
- R11: 010000 with instr[7:0] equal to 1, 2, 3 or 4 pulses `clrwdt_o`, `sleep_o`, `tmode_o` or `ret_o` respectively, with no writes and no flags. Every other word with instr[13:7]=0100000 has no effect on any output.
- R12: Any opcode not listed above produces no write, no flag enable, no skip and no strobe. `result_o` is 0 whenever neither write enable is high, and each flag output is 0 whenever its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 14 | Instruction word |
| w_i | input | 8 | Working register value |
| reg_i | input | 8 | Addressed file register value |
| c_i | input | 1 | Current carry flag |
| result_o | output | 8 | Result byte |
| w_we_o | output | 1 | Write result to W |
| reg_we_o | output | 1 | Write result to file register |
| addr_o | output | 7 | File register address |
| c_o | output | 1 | New carry |
| c_we_o | output | 1 | Carry update enable |
| hc_o | output | 1 | New half carry |
| hc_we_o | output | 1 | Half carry update enable |
| z_o | output | 1 | New zero flag |
| z_we_o | output | 1 | Zero update enable |
| skip_o | output | 1 | Skip next instruction |
| clrwdt_o | output | 1 | Watchdog clear strobe |
| sleep_o | output | 1 | Sleep strobe |
| tmode_o | output | 1 | Timer-mode load strobe |
| ret_o | output | 1 | Return strobe |

## Verification
Whenever the inputs settle, the assertions check several rules against the ports. The two write enables are mutually exclusive, and disabled flags read zero. The add and subtract results agree with their 9-bit sums, and rotates move the right bit into carry. Bit tests never write, strobes are at most one-hot, and a skip from increment or decrement comes only with a zero result. Only the bench's sweeps can show the full decode: that every opcode reaches the right operation, destination and flag set, that nibble-boundary operands give the right half carry, and that unlisted and control words stay silent.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 14;
  localparam int ADDR_W  = 7;
  localparam int NIB_W   = DATA_W / 2;
  localparam int BIT_W   = $clog2(DATA_W);

  localparam logic [5:0] OPC_ANDR  = 6'b010010;
  localparam logic [5:0] OPC_IORR  = 6'b010011;
  localparam logic [5:0] OPC_XORR  = 6'b010100;
  localparam logic [5:0] OPC_RL    = 6'b010101;
  localparam logic [5:0] OPC_RR    = 6'b010110;
  localparam logic [5:0] OPC_SWAP  = 6'b010111;
  localparam logic [5:0] OPC_MOV   = 6'b011000;
  localparam logic [5:0] OPC_INC   = 6'b011001;
  localparam logic [5:0] OPC_INCSZ = 6'b011010;
  localparam logic [5:0] OPC_ADD   = 6'b011011;
  localparam logic [5:0] OPC_SUB   = 6'b011100;
  localparam logic [5:0] OPC_DEC   = 6'b011101;
  localparam logic [5:0] OPC_DECSZ = 6'b011110;
  localparam logic [5:0] OPC_COM   = 6'b011111;
  localparam logic [5:0] OPC_MISC  = 6'b010000;
  localparam logic [5:0] OPC_CLRST = 6'b010001;
  localparam logic [5:0] OPC_ANDI  = 6'b110100;
  localparam logic [5:0] OPC_IORI  = 6'b110101;
  localparam logic [5:0] OPC_XORI  = 6'b110110;
  localparam logic [5:0] OPC_LDI   = 6'b111010;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_INC, OP_DEC,
    OP_AND, OP_IOR, OP_XOR, OP_RR, OP_RL, OP_SWAP, OP_COM,
    OP_PASSA, OP_PASSW, OP_ZERO, OP_BCLR, OP_BSET
  } alu_op_e;

  typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BCLR, SK_BSET} skip_e;

  typedef struct packed {
    alu_op_e op;
    logic    src_imm;
    logic    wr_w;
    logic    wr_reg;
    logic    c_en;
    logic    hc_en;
    logic    z_en;
    skip_e   skip;
    logic    clrwdt;
    logic    sleep;
    logic    tmode;
    logic    ret;
  } ctl_t;
endpackage

// File: rtl/byte_alu_decode.sv
module byte_alu_decode
  import byte_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctl_t               ctl_o
);
  logic [5:0] opc;
  logic       tsel;

  assign opc  = instr_i[13:8];
  assign tsel = instr_i[7];

  always_comb begin
    ctl_o      = '0;
    ctl_o.op   = OP_NONE;
    ctl_o.skip = SK_NONE;
    if (instr_i[13:12] == 2'b00) begin
      if (instr_i[10]) begin
        ctl_o.skip = instr_i[11] ? SK_BSET : SK_BCLR;
      end else begin
        ctl_o.op     = instr_i[11] ? OP_BSET : OP_BCLR;
        ctl_o.wr_reg = 1'b1;
      end
    end else begin
      case (opc)
        OPC_ADD, OPC_SUB: begin
          ctl_o.op     = (opc == OPC_ADD) ? OP_ADD : OP_SUB;
          ctl_o.wr_w   = ~tsel;
          ctl_o.wr_reg = tsel;
          ctl_o.c_en   = 1'b1;
          ctl_o.hc_en  = 1'b1;
          ctl_o.z_en   = 1'b1;
        end
        OPC_ANDR, OPC_IORR, OPC_XORR, OPC_COM, OPC_MOV, OPC_INC, OPC_DEC: begin
          unique case (opc)
            OPC_ANDR: ctl_o.op = OP_AND;
            OPC_IORR: ctl_o.op = OP_IOR;
            OPC_XORR: ctl_o.op = OP_XOR;
            OPC_COM:  ctl_o.op = OP_COM;
            OPC_MOV:  ctl_o.op = OP_PASSA;
            OPC_INC:  ctl_o.op = OP_INC;
            default:  ctl_o.op = OP_DEC;
          endcase
          ctl_o.wr_w   = ~tsel;
          ctl_o.wr_reg = tsel;
          ctl_o.z_en   = 1'b1;
        end
        OPC_RR, OPC_RL: begin
          ctl_o.op     = (opc == OPC_RR) ? OP_RR : OP_RL;
          ctl_o.wr_w   = ~tsel;
          ctl_o.wr_reg = tsel;
          ctl_o.c_en   = 1'b1;
        end
        OPC_SWAP: begin
          ctl_o.op     = OP_SWAP;
          ctl_o.wr_w   = ~tsel;
          ctl_o.wr_reg = tsel;
        end
        OPC_INCSZ, OPC_DECSZ: begin
          ctl_o.op     = (opc == OPC_INCSZ) ? OP_INC : OP_DEC;
          ctl_o.wr_w   = ~tsel;
          ctl_o.wr_reg = tsel;
          ctl_o.skip   = SK_ZERO;
        end
        OPC_ANDI, OPC_IORI, OPC_XORI: begin
          unique case (opc)
            OPC_ANDI: ctl_o.op = OP_AND;
            OPC_IORI: ctl_o.op = OP_IOR;
            default:  ctl_o.op = OP_XOR;
          endcase
          ctl_o.src_imm = 1'b1;
          ctl_o.wr_w    = 1'b1;
          ctl_o.z_en    = 1'b1;
        end
        OPC_LDI: begin
          ctl_o.op      = OP_PASSA;
          ctl_o.src_imm = 1'b1;
          ctl_o.wr_w    = 1'b1;
        end
        OPC_CLRST: begin
          ctl_o.wr_reg = 1'b1;
          if (tsel) begin
            ctl_o.op = OP_PASSW;
          end else begin
            ctl_o.op   = OP_ZERO;
            ctl_o.z_en = 1'b1;
          end
        end
        OPC_MISC: begin
          if (tsel) begin
            ctl_o.op   = OP_ZERO;
            ctl_o.wr_w = 1'b1;
            ctl_o.z_en = 1'b1;
          end else begin
            case (instr_i[6:0])
              7'd1:    ctl_o.clrwdt = 1'b1;
              7'd2:    ctl_o.sleep  = 1'b1;
              7'd3:    ctl_o.tmode  = 1'b1;
              7'd4:    ctl_o.ret    = 1'b1;
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] w_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              hc_o
);
  logic [DATA_W-1:0] b;
  logic              cin;
  logic [NIB_W:0]    lo_sum;
  logic [NIB_W:0]    hi_sum;

  // one adder: add, subtract (invert + carry in), increment, decrement (add all ones)
  always_comb begin
    unique case (op_i)
      OP_ADD:  begin b = w_i;            cin = 1'b0; end
      OP_SUB:  begin b = ~w_i;           cin = 1'b1; end
      OP_INC:  begin b = '0;             cin = 1'b1; end
      OP_DEC:  begin b = '1;             cin = 1'b0; end
      default: begin b = '0;             cin = 1'b0; end
    endcase
  end

  assign lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign hi_sum = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
                + {{NIB_W{1'b0}}, lo_sum[NIB_W]};

  assign res_o = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
  assign c_o   = hi_sum[NIB_W];
  assign hc_o  = lo_sum[NIB_W];
endmodule

// File: rtl/byte_alu_bitops.sv
module byte_alu_bitops
  import byte_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic              c_i,
  input  logic [BIT_W-1:0]  bsel_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (bsel_i == BIT_W'(i));
  end

  assign bit_o = |(a_i & mask);

  always_comb begin
    c_o = 1'b0;
    unique case (op_i)
      OP_AND:   res_o = a_i & w_i;
      OP_IOR:   res_o = a_i | w_i;
      OP_XOR:   res_o = a_i ^ w_i;
      OP_RR:    begin res_o = {c_i, a_i[DATA_W-1:1]}; c_o = a_i[0]; end
      OP_RL:    begin res_o = {a_i[DATA_W-2:0], c_i}; c_o = a_i[DATA_W-1]; end
      OP_SWAP:  res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
      OP_COM:   res_o = ~a_i;
      OP_PASSA: res_o = a_i;
      OP_PASSW: res_o = w_i;
      OP_BCLR:  res_o = a_i & ~mask;
      OP_BSET:  res_o = a_i | mask;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
  import byte_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  w_i,
  input  logic [DATA_W-1:0]  reg_i,
  input  logic               c_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               w_we_o,
  output logic               reg_we_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               c_o,
  output logic               c_we_o,
  output logic               hc_o,
  output logic               hc_we_o,
  output logic               z_o,
  output logic               z_we_o,
  output logic               skip_o,
  output logic               clrwdt_o,
  output logic               sleep_o,
  output logic               tmode_o,
  output logic               ret_o
);
  ctl_t              ctl;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] ar_res, bo_res, res;
  logic              ar_c, ar_hc, bo_c, bo_bit;
  logic              is_arith, res_zero, any_wr;

  byte_alu_decode u_dec (.instr_i(instr_i), .ctl_o(ctl));

  assign opa = ctl.src_imm ? instr_i[DATA_W-1:0] : reg_i;

  byte_alu_arith u_arith (
    .op_i(ctl.op), .a_i(opa), .w_i(w_i),
    .res_o(ar_res), .c_o(ar_c), .hc_o(ar_hc)
  );

  byte_alu_bitops u_bitops (
    .op_i(ctl.op), .a_i(opa), .w_i(w_i), .c_i(c_i),
    .bsel_i(instr_i[ADDR_W+BIT_W-1:ADDR_W]),
    .res_o(bo_res), .c_o(bo_c), .bit_o(bo_bit)
  );

  assign is_arith = ctl.op inside {OP_ADD, OP_SUB, OP_INC, OP_DEC};
  assign res      = is_arith ? ar_res : bo_res;
  assign res_zero = (res == '0);
  assign any_wr   = ctl.wr_w | ctl.wr_reg;

  always_comb begin
    unique case (ctl.skip)
      SK_ZERO: skip_o = res_zero;
      SK_BCLR: skip_o = ~bo_bit;
      SK_BSET: skip_o = bo_bit;
      default: skip_o = 1'b0;
    endcase
  end

  assign result_o = any_wr ? res : '0;
  assign w_we_o   = ctl.wr_w;
  assign reg_we_o = ctl.wr_reg;
  assign addr_o   = instr_i[ADDR_W-1:0];
  assign c_we_o   = ctl.c_en;
  assign c_o      = ctl.c_en & (is_arith ? ar_c : bo_c);
  assign hc_we_o  = ctl.hc_en;
  assign hc_o     = ctl.hc_en & ar_hc;
  assign z_we_o   = ctl.z_en;
  assign z_o      = ctl.z_en & res_zero;
  assign clrwdt_o = ctl.clrwdt;
  assign sleep_o  = ctl.sleep;
  assign tmode_o  = ctl.tmode;
  assign ret_o    = ctl.ret;
endmodule

// File: rtl/byte_alu_exec_chk.sv
module byte_alu_exec_chk (
  input logic [13:0] instr_i,
  input logic [7:0]  w_i,
  input logic [7:0]  reg_i,
  input logic        c_i,
  input logic [7:0]  result_o,
  input logic        w_we_o,
  input logic        reg_we_o,
  input logic [6:0]  addr_o,
  input logic        c_o,
  input logic        c_we_o,
  input logic        hc_o,
  input logic        hc_we_o,
  input logic        z_o,
  input logic        z_we_o,
  input logic        skip_o,
  input logic        clrwdt_o,
  input logic        sleep_o,
  input logic        tmode_o,
  input logic        ret_o
);
  logic       known;
  logic [8:0] add9, sub9;

  assign known = !$isunknown({instr_i, w_i, reg_i, c_i});
  assign add9  = {1'b0, w_i} + {1'b0, reg_i};
  assign sub9  = {1'b0, reg_i} + {1'b0, ~w_i} + 9'd1;

  always_comb begin
    if (known) begin
      a_r1_one_dest: assert (!(w_we_o && reg_we_o));
      a_r1_addr: assert (addr_o == instr_i[6:0]);
      a_r12_flags_quiet: assert ((c_we_o || !c_o) && (hc_we_o || !hc_o) && (z_we_o || !z_o));
      a_r12_result_quiet: assert (w_we_o || reg_we_o || result_o == 8'h00);
      a_r11_strobe_onehot: assert ($onehot0({clrwdt_o, sleep_o, tmode_o, ret_o}));
      if (instr_i[13:8] == 6'b011011) begin
        a_r2_add_sum: assert ({c_o, result_o} == add9);
      end
      if (instr_i[13:8] == 6'b011100) begin
        a_r3_sub_sum: assert ({c_o, result_o} == sub9);
      end
      if (instr_i[13:8] == 6'b010110) begin
        a_r5_rr_carry: assert (c_o == reg_i[0] && result_o[7] == c_i);
      end
      if (instr_i[13:12] == 2'b00 && instr_i[10]) begin
        a_r9_test_no_write: assert (!w_we_o && !reg_we_o);
      end
      if ((instr_i[13:8] == 6'b011010 || instr_i[13:8] == 6'b011110) && skip_o) begin
        a_r7_skip_zero: assert (result_o == 8'h00);
      end
    end
  end
endmodule

bind byte_alu_exec byte_alu_exec_chk u_chk (
  .instr_i(instr_i), .w_i(w_i), .reg_i(reg_i), .c_i(c_i),
  .result_o(result_o), .w_we_o(w_we_o), .reg_we_o(reg_we_o), .addr_o(addr_o),
  .c_o(c_o), .c_we_o(c_we_o), .hc_o(hc_o), .hc_we_o(hc_we_o),
  .z_o(z_o), .z_we_o(z_we_o), .skip_o(skip_o),
  .clrwdt_o(clrwdt_o), .sleep_o(sleep_o), .tmode_o(tmode_o), .ret_o(ret_o)
);

// File: tb/sim_byte_alu_exec.sv
module sim_byte_alu_exec;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [13:0] instr;
  logic [7:0]  w, r;
  logic        c;
  logic [7:0]  result;
  logic        w_we, reg_we, c_o, c_we, hc_o, hc_we, z_o, z_we, skip;
  logic        clrwdt, sleep, tmode, ret;
  logic [6:0]  addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  byte_alu_exec u0 (
    .instr_i(instr), .w_i(w), .reg_i(r), .c_i(c),
    .result_o(result), .w_we_o(w_we), .reg_we_o(reg_we), .addr_o(addr),
    .c_o(c_o), .c_we_o(c_we), .hc_o(hc_o), .hc_we_o(hc_we),
    .z_o(z_o), .z_we_o(z_we), .skip_o(skip),
    .clrwdt_o(clrwdt), .sleep_o(sleep), .tmode_o(tmode), .ret_o(ret)
  );

  // {w_we, reg_we, result, c_we, c, hc_we, hc, z_we, z, skip, clrwdt, sleep, tmode, ret}
  function automatic logic [20:0] model(input logic [13:0] ins, input logic [7:0] wv, rv,
                                        input logic ci);
    logic ww, rw, cw, cv, hw, hv, zw, sk, s1, s2, s3, s4, tdst;
    logic [7:0] res, imm;
    logic [5:0] opc;
    int sum, b;
    ww = 0; rw = 0; cw = 0; cv = 0; hw = 0; hv = 0; zw = 0; sk = 0;
    s1 = 0; s2 = 0; s3 = 0; s4 = 0; tdst = 0; res = 8'h00;
    opc = ins[13:8];
    imm = ins[7:0];
    if (ins[13:12] == 2'b00) begin
      b = int'(ins[9:7]);
      if (ins[10]) sk = ins[11] ? rv[b] : ~rv[b];
      else begin rw = 1; res = rv; res[b] = ins[11]; end
    end else begin
      case (opc)
        6'b011011: begin
          sum = int'(wv) + int'(rv);
          res = sum[7:0]; cv = (sum > 255);
          hv = (int'(wv) % 16 + int'(rv) % 16) > 15;
          cw = 1; hw = 1; zw = 1; tdst = 1;
        end
        6'b011100: begin
          res = rv - wv; cv = (rv >= wv); hv = (rv[3:0] >= wv[3:0]);
          cw = 1; hw = 1; zw = 1; tdst = 1;
        end
        6'b011001: begin res = rv + 8'd1; zw = 1; tdst = 1; end
        6'b011101: begin res = rv - 8'd1; zw = 1; tdst = 1; end
        6'b011010: begin res = rv + 8'd1; tdst = 1; sk = (res == 0); end
        6'b011110: begin res = rv - 8'd1; tdst = 1; sk = (res == 0); end
        6'b010010: begin res = rv & wv; zw = 1; tdst = 1; end
        6'b010011: begin res = rv | wv; zw = 1; tdst = 1; end
        6'b010100: begin res = rv ^ wv; zw = 1; tdst = 1; end
        6'b110100: begin res = imm & wv; zw = 1; ww = 1; end
        6'b110101: begin res = imm | wv; zw = 1; ww = 1; end
        6'b110110: begin res = imm ^ wv; zw = 1; ww = 1; end
        6'b010110: begin res = (rv >> 1) | (ci ? 8'h80 : 8'h00); cv = rv[0]; cw = 1; tdst = 1; end
        6'b010101: begin res = (rv << 1) | (ci ? 8'h01 : 8'h00); cv = rv[7]; cw = 1; tdst = 1; end
        6'b010111: begin res = (rv << 4) | (rv >> 4); tdst = 1; end
        6'b011111: begin res = 8'hFF - rv; zw = 1; tdst = 1; end
        6'b011000: begin res = rv; zw = 1; tdst = 1; end
        6'b111010: begin res = imm; ww = 1; end
        6'b010000: begin
          if (ins[7]) begin res = 0; ww = 1; zw = 1; end
          else case (ins[6:0])
            7'd1: s1 = 1;
            7'd2: s2 = 1;
            7'd3: s3 = 1;
            7'd4: s4 = 1;
            default: ;
          endcase
        end
        6'b010001: begin
          rw = 1;
          if (ins[7]) res = wv; else begin res = 0; zw = 1; end
        end
        default: ;
      endcase
    end
    if (tdst) begin ww = ~ins[7]; rw = ins[7]; end
    if (!(ww || rw)) res = 8'h00;
    return {ww, rw, res, cw, cv & cw, hw, hv & hw, zw, zw && (res == 0), sk, s1, s2, s3, s4};
  endfunction

  task automatic run(input logic [13:0] ins, input logic [7:0] wv, rv, input logic ci,
                     input string tag);
    logic [20:0] got, exp;
    @(negedge clk);
    instr = ins; w = wv; r = rv; c = ci;
    #1;
    exp = model(ins, wv, rv, ci);
    got = {w_we, reg_we, result, c_we, c_o, hc_we, hc_o, z_we, z_o, skip,
           clrwdt, sleep, tmode, ret};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s instr=%h w=%h r=%h c=%b got=%h exp=%h", tag, ins, wv, rv, ci, got, exp);
    end
    total++;
    if (addr !== ins[6:0]) begin
      bad++;
      $display("FAIL R1 addr instr=%h got=%h exp=%h", ins, addr, ins[6:0]);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    logic [3:0] n;
    n = j[3:0];
    return (j < 16) ? 8'(j * 17) : {n, ~n};
  endfunction

  logic [5:0] ops [15];
  string      tags [15];

  initial begin
    instr = '0; w = '0; r = '0; c = 1'b0;
    ops  = '{6'b011011, 6'b011100, 6'b010010, 6'b010011, 6'b010100, 6'b010110, 6'b010101,
             6'b010111, 6'b011111, 6'b011001, 6'b011101, 6'b011010, 6'b011110, 6'b011000,
             6'b010001};
    tags = '{"R2", "R3", "R4", "R4", "R4", "R5", "R5",
             "R6", "R6", "R7", "R7", "R7", "R7", "R10", "R10"};

    // initial all-zero word is a bit clear of reg 0 bit 0 (R8)
    run(14'h0000, 8'h00, 8'hFF, 1'b0, "R8");

    // R1..R7, R10: byte-register ops, both destinations, nibble-edge operands
    for (int k = 0; k < 15; k++)
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 32; i++)
          for (int j = 0; j < 32; j++)
            for (int cc = 0; cc < 2; cc++)
              run({ops[k], t[0], 7'(i * 3 + j)}, pat(i), pat(j), cc[0], tags[k]);

    // R4, R10: immediate forms always write W
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 32; i++)
        for (int j = 0; j < 32; j++) begin
          logic [5:0] o;
          o = (k == 0) ? 6'b110100 : (k == 1) ? 6'b110101 : (k == 2) ? 6'b110110 : 6'b111010;
          run({o, pat(j)}, pat(i), 8'h5A, 1'b1, (k == 3) ? "R10" : "R4");
        end

    // R8, R9: bit clear/set/test for every bit position over all register values
    for (int op = 0; op < 4; op++)
      for (int b = 0; b < 8; b++)
        for (int v = 0; v < 256; v++)
          run({2'b00, op[1:0], b[2:0], 7'h15}, 8'hC3, v[7:0], 1'b0, op[0] ? "R9" : "R8");

    // R10: clear W; R11: control words and silent neighbours
    for (int v = 0; v < 128; v++) begin
      run({6'b010000, 1'b1, v[6:0]}, 8'hA5, 8'h3C, 1'b1, "R10");
      run({6'b010000, 1'b0, v[6:0]}, 8'hA5, 8'h3C, 1'b1, "R11");
    end

    // R12: unlisted upper opcodes
    for (int o = 32; o < 64; o++)
      for (int i = 0; i < 8; i++)
        run({o[5:0], pat(i * 4 + 1)}, pat(i), pat(31 - i), i[0], "R12");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule